// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings a flat panel up and down in a fixed order, each step separated by a programmable delay. A free-running prescaler turns the core clock into a timing tick, nominally 100 µs. All step delays are counted in these ticks.

The power-up order is: panel supply, then the data port, then the backlight. Power-down runs the same steps in reverse. It ends with a minimum off period that is programmed in coarse units of 1000 ticks (100 ms), and a new power-up cannot start until that period has ended.

Software sets up the block through a small write port and reads it back through a combinational read port. The delay and divider registers accept writes only while the control register holds the unlock key. A reset-request input can force the panel down when the matching control bit is set.

Top module: `panel_pwr_seq`

## Requirements
- R1: Register map. Address 0 is control: bit 0 is the power request, bit 1 enables power-down on reset request, and bits 31:16 hold the key. Address 1 holds the power-up delay in bits 12:0 and the backlight-on delay in bits 28:16. Address 2 holds the power-down delay in bits 12:0 and the backlight-off delay in bits 28:16. Address 3 holds the tick divider in bits 15:0 and the cycle-delay field in bits 19:16. After reset, every register reads 0 and every output is low.
- R2: A step programmed with N ticks lasts exactly N·max(D,1)+1 clocks, where D is the divider value. A divider value of 0 behaves as 1.
- R3: Setting the power request while the block is off raises the supply enable one clock after the write edge. The data port then rises after the power-up delay step, and the backlight rises after the backlight-on step.
- R4: Clearing the power request while the block is on drops the backlight one clock after the write edge. The data port then falls after the backlight-off step, and the supply falls after the power-down step.
- R5: Panel-on rises together with the backlight at the end of power-up. It falls together with the supply at the end of power-down.
- R6: Sequence-busy is high in every transitional step and low only in the stable off and on states.
- R7: Cycle-delay-active rises when the supply falls and lasts a step of max(N-1,0)·UNIT ticks, where N is the cycle field and UNIT is the number of ticks per coarse unit.
- R8: A power request that is set while the cycle delay runs is held. The supply rises in the same clock in which cycle-delay-active falls.
- R9: Clearing the request during the supply-only step skips the data port and the backlight: the supply falls after the power-down step. Clearing it during the data-port step skips the backlight: the data port falls after the backlight-off step.
- R10: When the reset-request input pulses and control bit 1 is set, the power request is cleared and power-down starts. When bit 1 is clear, the pulse has no effect.
- R11: A write to address 1, 2 or 3 changes the register only if control bits 31:16 equal the key 0xA5C3 before the write. Otherwise the register reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| reset_req | input | 1 | Reset request that forces power-down when enabled |
| vdd_en | output | 1 | Panel supply enable |
| port_en | output | 1 | Data port enable |
| bl_en | output | 1 | Backlight enable |
| panel_on | output | 1 | Panel fully powered status |
| seq_busy | output | 1 | Sequence in progress |
| cyc_active | output | 1 | Minimum off period running |

## Verification
The control write lands on edge E, and the first output of the sequence (supply on, or backlight off) changes on edge E+1. Every later output edge follows the one before it by exactly N·max(D,1)+1 clocks. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the write, or from the output edge before, and compares that count with the figure from the same formula. Read-back values are combinational and are sampled one falling edge after the address is set.

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int          DLY_W    = 13,
  parameter int          DIV_W    = 16,
  parameter int          CYC_W    = 4,
  parameter int          CYC_UNIT = 1000,
  parameter logic [15:0] KEY      = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        reset_req,
  output logic        vdd_en,
  output logic        port_en,
  output logic        bl_en,
  output logic        panel_on,
  output logic        seq_busy,
  output logic        cyc_active
);
  localparam int T4_MAX = ((2**CYC_W) - 2) * CYC_UNIT;
  localparam int T4_W   = $clog2(T4_MAX + 1);
  localparam int CNT_W  = (T4_W > DLY_W) ? T4_W : DLY_W;

  typedef enum logic [2:0] {
    S_OFF, S_UP_VDD, S_UP_PORT, S_ON, S_DN_BL, S_DN_PORT, S_CYC
  } st_t;

  st_t state, nxt;
  logic              req_on, pdn_rst;
  logic [15:0]       key_q;
  logic [DLY_W-1:0]  up_dly, blon_dly, dn_dly, bloff_dly;
  logic [DIV_W-1:0]  ref_div, div_cnt, div_last;
  logic [CYC_W-1:0]  cyc_fld, cyc_units;
  logic [CNT_W-1:0]  cnt, load_val;
  logic              unlocked, tick, done;

  assign unlocked  = (key_q == KEY);
  assign div_last  = (ref_div == '0) ? '0 : ref_div - 1'b1;
  assign tick      = (div_cnt >= div_last);
  assign done      = (cnt == '0);
  assign cyc_units = (cyc_fld == '0) ? '0 : cyc_fld - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_on <= 1'b0; pdn_rst <= 1'b0; key_q <= '0;
      up_dly <= '0; blon_dly <= '0; dn_dly <= '0; bloff_dly <= '0;
      ref_div <= '0; cyc_fld <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            req_on  <= wr_data[0];
            pdn_rst <= wr_data[1];
            key_q   <= wr_data[31:16];
          end
          2'd1: if (unlocked) begin
            up_dly   <= wr_data[DLY_W-1:0];
            blon_dly <= wr_data[16 +: DLY_W];
          end
          2'd2: if (unlocked) begin
            dn_dly    <= wr_data[DLY_W-1:0];
            bloff_dly <= wr_data[16 +: DLY_W];
          end
          default: if (unlocked) begin
            ref_div <= wr_data[DIV_W-1:0];
            cyc_fld <= wr_data[16 +: CYC_W];
          end
        endcase
      end
      if (reset_req && pdn_rst) req_on <= 1'b0;
    end
  end

  always_comb begin
    nxt = state;
    case (state)
      S_OFF:     if (req_on) nxt = S_UP_VDD;
      S_UP_VDD:  if (!req_on) nxt = S_DN_PORT; else if (done) nxt = S_UP_PORT;
      S_UP_PORT: if (!req_on) nxt = S_DN_BL;   else if (done) nxt = S_ON;
      S_ON:      if (!req_on) nxt = S_DN_BL;
      S_DN_BL:   if (done) nxt = S_DN_PORT;
      S_DN_PORT: if (done) nxt = S_CYC;
      S_CYC:     if (done) nxt = req_on ? S_UP_VDD : S_OFF;
      default:   nxt = S_OFF;
    endcase
  end

  always_comb begin
    case (nxt)
      S_UP_VDD:  load_val = CNT_W'(up_dly);
      S_UP_PORT: load_val = CNT_W'(blon_dly);
      S_DN_BL:   load_val = CNT_W'(bloff_dly);
      S_DN_PORT: load_val = CNT_W'(dn_dly);
      S_CYC:     load_val = CNT_W'(cyc_units) * CNT_W'(CYC_UNIT);
      default:   load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF; cnt <= '0; div_cnt <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        cnt     <= load_val;
        div_cnt <= '0;
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick && !done) cnt <= cnt - 1'b1;
      end
    end
  end

  assign vdd_en     = (state != S_OFF) && (state != S_CYC);
  assign port_en    = (state == S_UP_PORT) || (state == S_ON) || (state == S_DN_BL);
  assign bl_en      = (state == S_ON);
  assign panel_on   = (state == S_ON) || (state == S_DN_BL) || (state == S_DN_PORT);
  assign seq_busy   = (state != S_OFF) && (state != S_ON);
  assign cyc_active = (state == S_CYC);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {key_q, 14'b0, pdn_rst, req_on};
      2'd1:    rd_data = (32'(blon_dly) << 16) | 32'(up_dly);
      2'd2:    rd_data = (32'(bloff_dly) << 16) | 32'(dn_dly);
      default: rd_data = (32'(cyc_fld) << 16) | 32'(ref_div);
    endcase
  end

  a_r3_port_after_vdd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_en) |-> $past(vdd_en));
  a_r3_bl_after_port: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bl_en) |-> $past(port_en));
  a_r4_vdd_off_after_port: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_en) |-> !$past(port_en));
  a_r5_panel_on_with_vdd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_on) |-> !vdd_en);
  a_r7_cycle_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_active |-> !vdd_en && !port_en && !bl_en);
  a_r6_stable_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (bl_en == vdd_en));
  a_r11_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !unlocked) |=> $stable(up_dly) && $stable(blon_dly));
endmodule

// File: tb/panel_pwr_seq_tb.sv
module panel_pwr_seq_tb;
  localparam int UNIT = 5;
  localparam logic [15:0] KEY = 16'hA5C3;
  localparam int LIM = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, reset_req = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic vdd_en, port_en, bl_en, panel_on, seq_busy, cyc_active;
  int n_chk = 0, n_bad = 0, port_rises = 0, bl_rises = 0;
  logic port_d = 1'b0, bl_d = 1'b0;

  always #4 clk = ~clk;

  panel_pwr_seq #(.CYC_UNIT(UNIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .reset_req(reset_req),
    .vdd_en(vdd_en), .port_en(port_en), .bl_en(bl_en), .panel_on(panel_on),
    .seq_busy(seq_busy), .cyc_active(cyc_active));

  always @(negedge clk) begin
    if (port_en && !port_d) port_rises++;
    if (bl_en && !bl_d) bl_rises++;
    port_d <= port_en; bl_d <= bl_en;
  end

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic int dur(input int n, input int d);
    return n * ((d == 0) ? 1 : d) + 1;
  endfunction
  function automatic int cdur(input int n, input int d);
    return ((n == 0) ? 0 : n - 1) * UNIT * ((d == 0) ? 1 : d) + 1;
  endfunction
  function automatic logic sig(input int s);
    case (s)
      0: return vdd_en; 1: return port_en; 2: return bl_en; default: return cyc_active;
    endcase
  endfunction

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic meas(input int s, input logic v, input int c0, output int c);
    c = c0;
    while (c < LIM) begin
      @(negedge clk); c++;
      if (sig(s) == v) break;
    end
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; @(negedge clk); d = rd_data;
  endtask
  task automatic prog(input int dv, input int tu, input int t5, input int t3, input int tx, input int n);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b0});
    wr(2'd1, (32'(t5) << 16) | 32'(tu));
    wr(2'd2, (32'(tx) << 16) | 32'(t3));
    wr(2'd3, (32'(n) << 16) | 32'(dv));
  endtask
  task automatic settle();
    int c;
    meas(3, 1'b0, 0, c);
    meas(0, 1'b0, 0, c);
    meas(3, 1'b0, 0, c);
  endtask

  initial begin
    int c, dv, tu, t5, t3, tx, n, pr, br;
    logic [31:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk("R1 reset vdd_en", vdd_en, 0);
    chk("R1 reset bl_en", bl_en, 0);
    chk("R6 reset seq_busy", seq_busy, 0);
    rst_n = 1'b1;
    rd(2'd1, d); chk("R1 reset reg1", d, 0);
    rd(2'd3, d); chk("R1 reset reg3", d, 0);

    // R11 locked write ignored, unlocked write accepted
    wr(2'd1, 32'h0003_0004);
    rd(2'd1, d); chk("R11 locked write ignored", d, 0);
    prog(2, 4, 3, 2, 1, 2);
    rd(2'd1, d); chk("R11 unlocked write reg1", d, 32'h0003_0004);
    rd(2'd0, d); chk("R1 control readback", d, {KEY, 16'h0002});
    rd(2'd3, d); chk("R1 reg3 fields", d, 32'h0002_0002);

    for (int it = 0; it < 8; it++) begin
      dv = $urandom % 4; tu = $urandom % 6; t5 = $urandom % 6;
      t3 = $urandom % 6; tx = $urandom % 6; n = $urandom % 4;
      if (it == 0) begin dv = 0; tu = 0; t5 = 0; t3 = 0; tx = 0; n = 0; end
      prog(dv, tu, t5, t3, tx, n);
      wr(2'd0, {KEY, 14'b0, 1'b1, 1'b1});
      meas(0, 1'b1, 1, c); chk("R3 vdd rise latency", c, 2);
      chk("R6 busy during power-up", seq_busy, 1);
      meas(1, 1'b1, 0, c); chk("R2 R3 power-up step", c, dur(tu, dv));
      meas(2, 1'b1, 0, c); chk("R2 R3 backlight-on step", c, dur(t5, dv));
      chk("R5 panel_on with backlight", panel_on, 1);
      chk("R6 busy low when on", seq_busy, 0);
      wr(2'd0, {KEY, 14'b0, 1'b1, 1'b0});
      meas(2, 1'b0, 1, c); chk("R4 backlight off latency", c, 2);
      chk("R5 panel_on held during power-down", panel_on, 1);
      meas(1, 1'b0, 0, c); chk("R4 backlight-off step", c, dur(tx, dv));
      meas(0, 1'b0, 0, c); chk("R4 power-down step", c, dur(t3, dv));
      chk("R5 panel_on falls with vdd", panel_on, 0);
      chk("R7 cycle delay starts", cyc_active, 1);
      meas(3, 1'b0, 0, c); chk("R7 cycle delay length", c, cdur(n, dv));
      chk("R6 busy low when off", seq_busy, 0);
    end

    // R8 pending power-on during cycle delay
    prog(2, 1, 1, 1, 1, 3);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b1});
    meas(2, 1'b1, 0, c);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b0});
    meas(3, 1'b1, 0, c);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b1});
    chk("R8 supply held off while cycle runs", vdd_en, 0);
    meas(3, 1'b0, 0, c);
    chk("R8 supply rises as cycle ends", vdd_en, 1);
    meas(2, 1'b1, 0, c);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b0});
    settle();

    // R9 abort during supply-only step
    prog(2, 5, 2, 3, 2, 1);
    pr = port_rises;
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b1});
    meas(0, 1'b1, 1, c);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b0});
    meas(0, 1'b0, 1, c); chk("R9 abort in supply step", c, 2 + dur(3, 2));
    chk("R9 data port never enabled", port_rises, pr);
    settle();

    // R9 abort during data-port step
    prog(2, 0, 6, 1, 3, 1);
    br = bl_rises;
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b1});
    meas(1, 1'b1, 0, c);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b0});
    meas(1, 1'b0, 1, c); chk("R9 abort in port step", c, 2 + dur(3, 2));
    chk("R9 backlight never enabled", bl_rises, br);
    settle();

    // R10 reset request with power-down enabled
    prog(1, 1, 1, 1, 1, 1);
    wr(2'd0, {KEY, 14'b0, 1'b1, 1'b1});
    meas(2, 1'b1, 0, c);
    @(negedge clk); reset_req = 1'b1; @(negedge clk); reset_req = 1'b0;
    meas(2, 1'b0, 1, c); chk("R10 forced power-down", c, 2);
    rd(2'd0, d); chk("R10 request cleared", d[0], 0);
    settle();

    // R10 reset request ignored when disabled
    wr(2'd0, {KEY, 14'b0, 1'b0, 1'b1});
    meas(2, 1'b1, 0, c);
    @(negedge clk); reset_req = 1'b1; @(negedge clk); reset_req = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 ignored when disabled", bl_en, 1);
    rd(2'd0, d); chk("R10 request kept", d[0], 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule